// File: doc/BRIEF.md
# Ripple Bit-Slice Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit built as a row of identical one-bit slices. Each slice holds an AND gate, an OR gate, a full adder with an optional inverter on its second operand, and a four-way output selector. Carries ripple from the least significant slice to the most significant one. A three-bit control word selects bitwise AND, bitwise OR, addition, subtraction or a signed less-than comparison.

The top bit of the control word is the operand-invert flag, and it is also the carry into the lowest slice, so subtraction is formed as a + ~b + 1. The signed comparison runs that same subtraction. It then takes the true sign of the difference, which is the top sum bit corrected by the overflow condition, and feeds it back into the lowest slice's "less" selector input. Every other slice sees a constant 0 on that input. Flags for a zero result, signed overflow and adder carry-out come with the result. A datapath instantiates the block and reads the result in the same cycle.

Top module: `bitslice_alu`

## Requirements
- R1: Control 3'b000 gives result = a AND b, bit by bit.
- R2: Control 3'b001 gives result = a OR b, bit by bit.
- R3: Control 3'b010 gives result = (a + b) modulo 2^WIDTH.
- R4: Control 3'b110 gives result = (a - b) modulo 2^WIDTH, computed as a + ~b + 1.
- R5: Control 3'b111 gives result = 1 when a is less than b as two's-complement signed numbers, and 0 otherwise. All bits above bit 0 are 0. The answer stays correct when a - b overflows.
- R6: zero_o is 1 exactly when every bit of result_o is 0, for every control code.
- R7: overflow_o is 1 only for codes 3'b010 and 3'b110, and then exactly when the signed sum or difference does not fit in WIDTH bits. For all other codes it is 0.
- R8: carry_o is the carry out of the top slice of a + (ctrl[2] ? ~b : b) + ctrl[2], for every control code.
- R9: The codes 3'b011, 3'b100 and 3'b101 give result 0 (and so zero_o = 1) and overflow_o = 0, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| ctrl_i | input | 3 | {invert, select[1:0]}; codes listed in R1 to R5 and R9 |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | Result is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |
| carry_o | output | 1 | Carry out of the top slice |

## Verification
Each operation is tried with operand pairs chosen so that a wrong select, a missing invert or a missing carry-in produces a different value. Addition and subtraction cases sit at the signed limits (0x7FFFFFFF, 0x80000000, all ones), which separates carry-out from signed overflow. The comparison is tried across sign boundaries where the raw sign of the difference lies, so a design that skips the overflow correction fails. A single set bit is walked across every position of the result to show that the zero detector covers each bit. The unused codes are driven with non-zero operands to confirm that nothing leaks through.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } slice_sel_e;

  localparam logic [2:0] CODE_AND = 3'b000;
  localparam logic [2:0] CODE_OR  = 3'b001;
  localparam logic [2:0] CODE_ADD = 3'b010;
  localparam logic [2:0] CODE_SUB = 3'b110;
  localparam logic [2:0] CODE_SLT = 3'b111;

  // {carry, sum} of a one-bit full adder
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic c);
    full_add = {(x & y) | (x & c) | (y & c), x ^ y ^ c};
  endfunction

  function automatic logic code_is_valid(input logic [2:0] code);
    code_is_valid = (code == CODE_AND) || (code == CODE_OR) || (code == CODE_ADD) ||
                    (code == CODE_SUB) || (code == CODE_SLT);
  endfunction

  function automatic logic code_is_arith(input logic [2:0] code);
    code_is_arith = (code == CODE_ADD) || (code == CODE_SUB);
  endfunction

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import alu_pkg::*;
(
  input  logic [2:0]  ctrl_i,
  output logic        binv_o,
  output slice_sel_e  sel_o,
  output logic        valid_o,
  output logic        arith_o
);
  always_comb begin
    binv_o  = ctrl_i[2];
    sel_o   = slice_sel_e'(ctrl_i[1:0]);
    valid_o = code_is_valid(ctrl_i);
    arith_o = code_is_arith(ctrl_i);
  end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       binv_i,
  input  logic       carry_i,
  input  logic       less_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       carry_o
);
  logic       b_eff;
  logic [1:0] add_w;

  always_comb begin
    b_eff = b_i ^ binv_i;
    add_w = full_add(a_i, b_eff, carry_i);
    carry_o = add_w[1];
    case (sel_i)
      SEL_AND:  res_o = a_i & b_i;
      SEL_OR:   res_o = a_i | b_i;
      SEL_SUM:  res_o = add_w[0];
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_msb_flags.sv
module alu_msb_flags (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic binv_i,
  input  logic carry_in_i,
  input  logic carry_out_i,
  input  logic arith_i,
  output logic raw_ovf_o,
  output logic overflow_o,
  output logic set_o
);
  logic sum_msb;

  always_comb begin
    sum_msb    = a_msb_i ^ b_msb_i ^ binv_i ^ carry_in_i;
    raw_ovf_o  = carry_in_i ^ carry_out_i;
    overflow_o = raw_ovf_o & arith_i;
    // true sign of the difference, corrected when it overflowed
    set_o      = sum_msb ^ raw_ovf_o;
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);
  assign zero_o = ~(|vec_i);
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic             carry_o
);
  localparam int MSB = WIDTH - 1;

  logic       binv_w;
  slice_sel_e sel_w;
  logic       valid_w;
  logic       arith_w;
  logic       set_w;
  logic       raw_ovf_w;

  logic [WIDTH:0]   carry_w;
  logic [WIDTH-1:0] slice_res_w;

  alu_ctrl_decode u_dec (
    .ctrl_i  (ctrl_i),
    .binv_o  (binv_w),
    .sel_o   (sel_w),
    .valid_o (valid_w),
    .arith_o (arith_w)
  );

  assign carry_w[0] = binv_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic less_w;
    if (i == 0) begin : g_lsb
      assign less_w = set_w;
    end else begin : g_upper
      assign less_w = 1'b0;
    end
    alu_bit_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .binv_i  (binv_w),
      .carry_i (carry_w[i]),
      .less_i  (less_w),
      .sel_i   (sel_w),
      .res_o   (slice_res_w[i]),
      .carry_o (carry_w[i+1])
    );
  end

  alu_msb_flags u_msb (
    .a_msb_i     (a_i[MSB]),
    .b_msb_i     (b_i[MSB]),
    .binv_i      (binv_w),
    .carry_in_i  (carry_w[MSB]),
    .carry_out_i (carry_w[WIDTH]),
    .arith_i     (arith_w),
    .raw_ovf_o   (raw_ovf_w),
    .overflow_o  (overflow_o),
    .set_o       (set_w)
  );

  assign result_o = slice_res_w & {WIDTH{valid_w}};
  assign carry_o  = carry_w[WIDTH];

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .vec_i  (result_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       ctrl_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             overflow_o,
  input logic             carry_o
);
  always_comb begin
    if (ctrl_i == 3'b000)
      assert_and_R1: assert (result_o == (a_i & b_i));
    if (ctrl_i == 3'b010)
      assert_add_R3: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}));
    if (ctrl_i == 3'b111)
      assert_slt_single_bit_R5: assert (result_o[WIDTH-1:1] == '0);
    assert_zero_flag_R6: assert (zero_o == (result_o == '0));
    if (ctrl_i != 3'b010 && ctrl_i != 3'b110)
      assert_no_overflow_R7: assert (!overflow_o);
    if (ctrl_i == 3'b011 || ctrl_i == 3'b100 || ctrl_i == 3'b101)
      assert_unused_code_R9: assert (result_o == '0 && zero_o);
  end
endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .ctrl_i     (ctrl_i),
  .result_o   (result_o),
  .zero_o     (zero_o),
  .overflow_o (overflow_o),
  .carry_o    (carry_o)
);

// File: tb/bitslice_alu_tb_top.sv
module bitslice_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int WATCHDOG = 5000;

  typedef struct packed {
    logic [2:0]   c;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 32'hF0F0_F0F0, 32'h0FF0_0FF0},  // R1
    '{3'b000, 32'hFFFF_FFFF, 32'h1234_5678},  // R1
    '{3'b000, 32'hAAAA_AAAA, 32'h5555_5555},  // R1 zero result
    '{3'b001, 32'h0000_F000, 32'h0000_0F0F},  // R2
    '{3'b001, 32'h0000_0000, 32'h0000_0000},  // R2 zero result
    '{3'b010, 32'h0000_0001, 32'h0000_0002},  // R3
    '{3'b010, 32'h7FFF_FFFF, 32'h0000_0001},  // R3 signed overflow
    '{3'b010, 32'hFFFF_FFFF, 32'h0000_0001},  // R3 carry, zero
    '{3'b010, 32'h8000_0000, 32'h8000_0000},  // R3 overflow and carry
    '{3'b110, 32'h0000_0005, 32'h0000_0003},  // R4
    '{3'b110, 32'h0000_0003, 32'h0000_0005},  // R4 borrow
    '{3'b110, 32'h8000_0000, 32'h0000_0001},  // R4 overflow
    '{3'b110, 32'h0000_0000, 32'h0000_0000},  // R4 zero, carry set
    '{3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF},  // R4 overflow other side
    '{3'b111, 32'h0000_0003, 32'h0000_0005},  // R5 true
    '{3'b111, 32'h0000_0005, 32'h0000_0003},  // R5 false
    '{3'b111, 32'hFFFF_FFFF, 32'h0000_0001},  // R5 negative vs positive
    '{3'b111, 32'h8000_0000, 32'h7FFF_FFFF},  // R5 difference overflows, true
    '{3'b111, 32'h7FFF_FFFF, 32'h8000_0000},  // R5 difference overflows, false
    '{3'b111, 32'h1234_5678, 32'h1234_5678},  // R5 equal
    '{3'b111, 32'hFFFF_FFFE, 32'hFFFF_FFFF},  // R5 both negative
    '{3'b011, 32'hDEAD_BEEF, 32'h1234_5678},  // R9
    '{3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R9
    '{3'b101, 32'h7FFF_FFFF, 32'h0000_0001},  // R9
    '{3'b011, 32'h0000_0001, 32'h0000_0002}   // R9 (would be slt without invert)
  };

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [2:0]   ctrl;
  logic [W-1:0] result;
  logic         zero, ovf, carry;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitslice_alu #(.WIDTH(W)) dut_i (
    .a_i        (a),
    .b_i        (b),
    .ctrl_i     (ctrl),
    .result_o   (result),
    .zero_o     (zero),
    .overflow_o (ovf),
    .carry_o    (carry)
  );

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'b000:  tag_of = "R1";
      3'b001:  tag_of = "R2";
      3'b010:  tag_of = "R3";
      3'b110:  tag_of = "R4";
      3'b111:  tag_of = "R5";
      default: tag_of = "R9";
    endcase
  endfunction

  // Expected values written from the requirements
  task automatic model(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y,
                       output logic [W-1:0] r, output logic z, output logic o, output logic co);
    logic [W:0]   s;
    logic [W-1:0] yy;
    logic         inv;
    inv = c[2];
    yy  = inv ? ~y : y;
    s   = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, inv};
    co  = s[W];
    case (c)
      3'b000:  r = x & y;
      3'b001:  r = x | y;
      3'b010:  r = x + y;
      3'b110:  r = x - y;
      3'b111:  r = ($signed(x) < $signed(y)) ? {{(W-1){1'b0}}, 1'b1} : '0;
      default: r = '0;
    endcase
    o = ((c == 3'b010) || (c == 3'b110)) && (x[W-1] == yy[W-1]) && (s[W-1] != x[W-1]);
    z = (r == '0);
  endtask

  task automatic check_bit(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s ctrl=%b a=%h b=%h: got %b expected %b", tag, what, ctrl, a, b, got, exp);
    end
  endtask

  task automatic check_word(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s result ctrl=%b a=%h b=%h: got %h expected %h", tag, ctrl, a, b, got, exp);
    end
  endtask

  task automatic apply_and_check(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] er;
    logic ez, eo, ec;
    @(posedge clk);
    ctrl = c; a = x; b = y;
    @(negedge clk);
    model(c, x, y, er, ez, eo, ec);
    check_word(tag_of(c), result, er);
    check_bit("R6", "zero", zero, ez);
    check_bit("R7", "overflow", ovf, eo);
    check_bit("R8", "carry", carry, ec);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; ctrl = 3'b000;
    @(negedge clk);
    // Start-up state: zero operands with AND give an all-zero result (R1, R6)
    check_word("R1", result, '0);
    check_bit("R6", "zero", zero, 1'b1);
    check_bit("R7", "overflow", ovf, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply_and_check(VECS[i].c, VECS[i].a, VECS[i].b);
    end

    // R6: a single set bit at each position must clear the zero flag (OR mode, R2)
    for (int i = 0; i < W; i++) begin
      apply_and_check(3'b001, {{(W-1){1'b0}}, 1'b1} << i, '0);
    end

    // R5: comparisons one step either side of zero
    apply_and_check(3'b111, 32'hFFFF_FFFF, 32'h0000_0000);
    apply_and_check(3'b111, 32'h0000_0000, 32'hFFFF_FFFF);
    // R8: carry reported for AND/OR codes too, from a + b
    apply_and_check(3'b000, 32'hFFFF_FFFF, 32'h0000_0001);
    // R9: unused code with inverted operand and carry-out
    apply_and_check(3'b100, 32'h0000_0000, 32'h0000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule